// File: doc/BRIEF.md
# Census Stereo Matcher with Left-Right Cross-Check

This block receives two streams of 48-bit census signatures, one from the left camera and one from the right. Both streams arrive together in raster order, one pixel pair per accepted cycle. For every pixel it runs two independent searches over `NCAND` candidate shifts (0 to 63 by default). The forward search compares the current left signature with the present and earlier right signatures. The backward search compares a right signature with the left signatures that follow it. A candidate's score is the number of bit positions in which the two signatures agree. A pipelined pyramid of compare/select units finds the best shift, carrying the shift index along with the score.

The two winning shifts are then cross-checked. When they lie closer together than a threshold supplied at run time, the forward shift is emitted. When they do not, the block emits a reserved "undefined" code equal to `NCAND`. The backward answer for a pixel needs the `NCAND-1` left signatures that follow it, so the forward answer is held back the same number of pixels before the two are compared. At the end of a frame, feeding further pixels pushes out the remaining results.

Top module: `census_lr_matcher`

## Requirements
- R1: A result whose forward and backward shifts differ by less than `thresh` carries the forward shift. Any other result carries the undefined code, whose value is `NCAND` (64).
- R2: A candidate's score is the count of equal bit positions between the two 48-bit signatures. Among the candidates of one search, the highest score wins.
- R3: The forward search for the left pixel in column u scores the right pixels in columns u−d of the same row, for d = 0 to `NCAND-1`. Here d = 0 is the right pixel that arrives with it.
- R4: The backward search for the right pixel in column u scores the left pixels in columns u+d of the same row, for d = 0 to `NCAND-1`.
- R5: When several candidates share the top score, the smallest shift wins.
- R6: A candidate that falls outside the row scores zero. This covers u−d < 0 and u+d > `ROW_W-1`, with columns counted from 0 at the first pixel after reset and wrapping every `ROW_W` pixels.
- R7: The result for pixel p is produced when pixel p+`NCAND-1` is accepted, on `out_valid`. It appears 7 clock edges after the edge that samples that later pixel. The first `NCAND-1` accepted pixels produce no result.
- R8: A cycle with `in_valid` low is ignored. It advances no column, history or result.
- R9: While reset is held, `out_valid` and `out_disp` are 0.
- R10: A threshold of 0 turns every result into the undefined code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel pair is present this cycle |
| left_sig | input | SIG_W | Left census signature |
| right_sig | input | SIG_W | Right census signature |
| thresh | input | $clog2(NCAND+1) | Cross-check threshold, sampled at the final stage |
| out_valid | output | 1 | A validated result is present |
| out_disp | output | $clog2(NCAND+1) | Forward shift, or `NCAND` when the check fails |

## Verification
Scenes with a planted shift of 5, 12, 20 or 40 columns show whether each search reaches the true shift from its own side. A shift of 40 also pushes many backward candidates past the row end. Uniform signatures make every in-row score equal, which isolates the smallest-shift tie rule. Fully independent random streams make the two searches disagree, so the undefined path and the threshold compare are exercised heavily. Bubbles in `in_valid`, zero and wide thresholds, and a 160-column row test the stall behaviour, the fusion rule and both row edges against a behavioural model that is compared on every cycle.

// File: rtl/cm_pkg.sv
package cm_pkg;

  // Distance between two shift indices.
  function automatic int unsigned cm_abs_gap(input int a, input int b);
    return (a > b) ? int'(a - b) : int'(b - a);
  endfunction

  // Tie rule: the higher-index candidate wins only with a strictly larger score.
  function automatic bit cm_prefer_upper(input int lower_sc, input int upper_sc);
    return upper_sc > lower_sc;
  endfunction

endpackage

// File: rtl/cm_score_bank.sv
module cm_score_bank #(
  parameter int unsigned SIG_W = 48,
  parameter int unsigned NCAND = 64,
  parameter int unsigned SCW   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          v_i,
  input  logic [SIG_W-1:0]              probe,
  input  logic [NCAND-1:0][SIG_W-1:0]   cands,
  input  logic [NCAND-1:0]              ok,
  output logic                          v_o,
  output logic [NCAND-1:0][SCW-1:0]     sc_o
);

  function automatic logic [SCW-1:0] agree_count(input logic [SIG_W-1:0] a,
                                                 input logic [SIG_W-1:0] b);
    logic [SIG_W-1:0] same;
    logic [SCW-1:0]   n;
    same = ~(a ^ b);
    n = '0;
    for (int i = 0; i < int'(SIG_W); i++) n = n + SCW'(same[i]);
    return n;
  endfunction

  logic [NCAND-1:0][SCW-1:0] raw_sc;

  always_comb begin
    for (int k = 0; k < int'(NCAND); k++)
      raw_sc[k] = ok[k] ? agree_count(probe, cands[k]) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      sc_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) sc_o <= raw_sc;
    end
  end

  for (genvar k = 0; k < NCAND; k++) begin : g_chk
    // R2
    score_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_o |-> (int'(sc_o[k]) <= int'(SIG_W)));
    // R6
    out_of_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !ok[k]) |=> (sc_o[k] == '0));
  end

endmodule

// File: rtl/cm_argmax_tree.sv
module cm_argmax_tree #(
  parameter int unsigned NCAND = 64,
  parameter int unsigned SCW   = 6,
  parameter int unsigned IW    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      v_i,
  input  logic [NCAND-1:0][SCW-1:0] sc_i,
  output logic                      v_o,
  output logic [SCW-1:0]            sc_o,
  output logic [IW-1:0]             ix_o
);
  import cm_pkg::*;

  localparam int unsigned LEVELS = $clog2(NCAND);

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lv
    localparam int unsigned NI = NCAND >> lv;
    localparam int unsigned NO = NI >> 1;

    logic [NI-1:0][SCW-1:0] in_sc;
    logic [NI-1:0][IW-1:0]  in_ix;
    logic                   in_v;
    logic [NO-1:0][SCW-1:0] out_sc;
    logic [NO-1:0][IW-1:0]  out_ix;
    logic                   out_v;

    if (lv == 0) begin : g_head
      assign in_sc = sc_i;
      assign in_v  = v_i;
      for (genvar k = 0; k < NI; k++) begin : g_seed
        assign in_ix[k] = IW'(k);
      end
    end else begin : g_link
      assign in_sc = g_lv[lv-1].out_sc;
      assign in_ix = g_lv[lv-1].out_ix;
      assign in_v  = g_lv[lv-1].out_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_v  <= 1'b0;
        out_sc <= '0;
        out_ix <= '0;
      end else begin
        out_v <= in_v;
        for (int u = 0; u < int'(NO); u++) begin
          if (cm_prefer_upper(int'(in_sc[2*u]), int'(in_sc[2*u+1]))) begin
            out_sc[u] <= in_sc[2*u+1];
            out_ix[u] <= in_ix[2*u+1];
          end else begin
            out_sc[u] <= in_sc[2*u];
            out_ix[u] <= in_ix[2*u];
          end
        end
      end
    end

    for (genvar u = 0; u < NO; u++) begin : g_unit_chk
      // R2
      keep_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_v |=> ((out_sc[u] >= $past(in_sc[2*u])) && (out_sc[u] >= $past(in_sc[2*u+1]))));
      // R5
      tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && (in_sc[2*u] == in_sc[2*u+1])) |=> (out_ix[u] == $past(in_ix[2*u])));
    end
  end

  assign v_o  = g_lv[LEVELS-1].out_v;
  assign sc_o = g_lv[LEVELS-1].out_sc[0];
  assign ix_o = g_lv[LEVELS-1].out_ix[0];

endmodule

// File: rtl/cm_fuse.sv
module cm_fuse #(
  parameter int unsigned NCAND = 64,
  parameter int unsigned IW    = 6,
  parameter int unsigned DW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_v,
  input  logic [IW-1:0] lr_d,
  input  logic          rl_v,
  input  logic [IW-1:0] rl_d,
  input  logic [DW-1:0] thresh,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  import cm_pkg::*;

  localparam int unsigned DEPTH = NCAND - 1;
  localparam logic [DW-1:0] UNDEF = DW'(NCAND);

  // Forward answers, newest in slot 0; slot DEPTH-1 pairs with the backward answer.
  logic [DEPTH-1:0][IW-1:0] lr_hold;
  logic [IW-1:0]            lr_aligned;
  logic                     agree;

  assign lr_aligned = lr_hold[DEPTH-1];
  assign agree = cm_abs_gap(int'(lr_aligned), int'(rl_d)) < int'(thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_hold <= '0;
      out_v   <= 1'b0;
      out_d   <= '0;
    end else begin
      if (lr_v) begin
        lr_hold[0] <= lr_d;
        for (int k = 1; k < int'(DEPTH); k++) lr_hold[k] <= lr_hold[k-1];
      end
      out_v <= rl_v;
      if (rl_v) out_d <= agree ? DW'(lr_aligned) : UNDEF;
    end
  end

  // R10
  zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_v && (thresh == '0)) |=> (out_d == UNDEF));
  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> (out_d <= UNDEF));
  // R7
  paired_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl_v |-> lr_v);

endmodule

// File: rtl/census_lr_matcher.sv
module census_lr_matcher #(
  parameter int unsigned SIG_W = 48,
  parameter int unsigned NCAND = 64,
  parameter int unsigned ROW_W = 640
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [SIG_W-1:0]             left_sig,
  input  logic [SIG_W-1:0]             right_sig,
  input  logic [$clog2(NCAND+1)-1:0]   thresh,
  output logic                         out_valid,
  output logic [$clog2(NCAND+1)-1:0]   out_disp
);

  localparam int unsigned DW  = $clog2(NCAND + 1);
  localparam int unsigned IW  = $clog2(NCAND);
  localparam int unsigned SCW = $clog2(SIG_W + 1);
  localparam int unsigned CW  = (ROW_W > 1) ? $clog2(ROW_W) : 1;
  localparam int unsigned HD  = NCAND - 1;

  logic [CW-1:0]            col_q;
  logic [CW-1:0]            rl_col_q;
  logic [IW-1:0]            fill_q;
  logic                     primed;
  logic [HD-1:0][SIG_W-1:0] lhist;
  logic [HD-1:0][SIG_W-1:0] rhist;

  assign primed = (fill_q == IW'(HD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      rl_col_q <= '0;
      fill_q   <= '0;
      lhist    <= '0;
      rhist    <= '0;
    end else if (in_valid) begin
      col_q <= (int'(col_q) == int'(ROW_W) - 1) ? '0 : col_q + 1'b1;
      if (primed)
        rl_col_q <= (int'(rl_col_q) == int'(ROW_W) - 1) ? '0 : rl_col_q + 1'b1;
      else
        fill_q <= fill_q + 1'b1;
      lhist[0] <= left_sig;
      rhist[0] <= right_sig;
      for (int k = 1; k < int'(HD); k++) begin
        lhist[k] <= lhist[k-1];
        rhist[k] <= rhist[k-1];
      end
    end
  end

  // Candidate windows and in-row masks for both searches.
  logic [NCAND-1:0][SIG_W-1:0] lr_cand, rl_cand;
  logic [NCAND-1:0]            lr_ok, rl_ok;
  logic [SIG_W-1:0]            rl_probe;
  logic                        rl_go;

  assign rl_probe = rhist[HD-1];
  assign rl_go    = in_valid && primed;

  for (genvar d = 0; d < NCAND; d++) begin : g_cand
    if (d == 0) begin : g_now
      assign lr_cand[d] = right_sig;
    end else begin : g_old
      assign lr_cand[d] = rhist[d-1];
    end
    if (d == NCAND - 1) begin : g_newest
      assign rl_cand[d] = left_sig;
    end else begin : g_older
      assign rl_cand[d] = lhist[HD-1-d];
    end
    assign lr_ok[d] = (int'(col_q) >= d);
    assign rl_ok[d] = (int'(rl_col_q) + d <= int'(ROW_W) - 1);
  end

  logic                      lr_sv, rl_sv;
  logic [NCAND-1:0][SCW-1:0] lr_sc, rl_sc;

  cm_score_bank #(.SIG_W(SIG_W), .NCAND(NCAND), .SCW(SCW)) u_lr_bank (
    .clk(clk), .rst_n(rst_n), .v_i(in_valid), .probe(left_sig),
    .cands(lr_cand), .ok(lr_ok), .v_o(lr_sv), .sc_o(lr_sc));

  cm_score_bank #(.SIG_W(SIG_W), .NCAND(NCAND), .SCW(SCW)) u_rl_bank (
    .clk(clk), .rst_n(rst_n), .v_i(rl_go), .probe(rl_probe),
    .cands(rl_cand), .ok(rl_ok), .v_o(rl_sv), .sc_o(rl_sc));

  logic           lr_bv, rl_bv;
  logic [SCW-1:0] lr_best_sc, rl_best_sc;
  logic [IW-1:0]  lr_best_ix, rl_best_ix;

  cm_argmax_tree #(.NCAND(NCAND), .SCW(SCW), .IW(IW)) u_lr_tree (
    .clk(clk), .rst_n(rst_n), .v_i(lr_sv), .sc_i(lr_sc),
    .v_o(lr_bv), .sc_o(lr_best_sc), .ix_o(lr_best_ix));

  cm_argmax_tree #(.NCAND(NCAND), .SCW(SCW), .IW(IW)) u_rl_tree (
    .clk(clk), .rst_n(rst_n), .v_i(rl_sv), .sc_i(rl_sc),
    .v_o(rl_bv), .sc_o(rl_best_sc), .ix_o(rl_best_ix));

  cm_fuse #(.NCAND(NCAND), .IW(IW), .DW(DW)) u_fuse (
    .clk(clk), .rst_n(rst_n),
    .lr_v(lr_bv), .lr_d(lr_best_ix),
    .rl_v(rl_bv), .rl_d(rl_best_ix),
    .thresh(thresh), .out_v(out_valid), .out_d(out_disp));

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_q) < int'(ROW_W)) && (int'(rl_col_q) < int'(ROW_W)));
  // R7
  prime_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> primed);
  // R2
  best_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_bv |-> int'(lr_best_sc) <= int'(SIG_W)) and (rl_bv |-> int'(rl_best_sc) <= int'(SIG_W)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(col_q) && $stable(fill_q)));

endmodule

// File: tb/census_lr_matcher_test.sv
module census_lr_matcher_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW  = 48;
  localparam int NC  = 64;
  localparam int W   = 160;
  localparam int LAT = 7;
  localparam int UND = NC;
  localparam int NPX = 4096;
  localparam int NCY = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] left_sig = '0;
  logic [SW-1:0] right_sig = '0;
  logic [6:0]    thresh = '0;
  logic          out_valid;
  logic [6:0]    out_disp;

  census_lr_matcher #(.SIG_W(SW), .NCAND(NC), .ROW_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .left_sig(left_sig), .right_sig(right_sig), .thresh(thresh),
    .out_valid(out_valid), .out_disp(out_disp));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [SW-1:0] scene [0:NPX+NC];
  logic [SW-1:0] sl [0:NPX-1];
  logic [SW-1:0] sr [0:NPX-1];
  int ptag [0:NPX-1];
  bit ev [0:NCY-1];
  int ep [0:NCY-1];
  int npix = 0;
  int cur_tag = 0;

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      8: return "R8";
      10: return "R10";
      default: return "R7";
    endcase
  endfunction

  function automatic int agree(input logic [SW-1:0] a, input logic [SW-1:0] b);
    int n = 0;
    for (int i = 0; i < SW; i++) if (a[i] == b[i]) n++;
    return n;
  endfunction

  // Forward: left pixel p against right pixels p-d inside the row.
  function automatic int fwd_best(input int p);
    int u = p % W;
    int best = -1;
    int bd = 0;
    for (int d = 0; d < NC; d++) begin
      int s = (d <= u) ? agree(sl[p], sr[p-d]) : 0;
      if (s > best) begin best = s; bd = d; end
    end
    return bd;
  endfunction

  // Backward: right pixel p against left pixels p+d inside the row.
  function automatic int bwd_best(input int p);
    int u = p % W;
    int best = -1;
    int bd = 0;
    for (int d = 0; d < NC; d++) begin
      int s = (u + d <= W - 1) ? agree(sr[p], sl[p+d]) : 0;
      if (s > best) begin best = s; bd = d; end
    end
    return bd;
  endfunction

  task automatic check_outputs();
    int idx = cyc - LAT;
    bit xv = (idx >= 0 && idx < NCY) ? ev[idx] : 1'b0;
    checks++;
    if (out_valid !== xv) begin
      errors++;
      $display("FAIL R7 cycle %0d out_valid actual %0b expected %0b", cyc, out_valid, xv);
    end else if (xv) begin
      int p = ep[idx];
      int a = fwd_best(p);
      int b = bwd_best(p);
      int gap = (a > b) ? a - b : b - a;
      int xd = (gap < int'(thresh)) ? a : UND;
      int col = p % W;
      string tg = (col < NC - 1 || col > W - NC) ? "R6" : tag_name(ptag[p]);
      checks++;
      if (int'(out_disp) != xd) begin
        errors++;
        $display("FAIL %s pixel %0d out_disp actual %0d expected %0d", tg, p, out_disp, xd);
      end
    end
  endtask

  task automatic step(input bit v, input logic [SW-1:0] l, input logic [SW-1:0] r, input int thr);
    @(negedge clk);
    check_outputs();
    thresh = thr[6:0];
    in_valid = v;
    left_sig = l;
    right_sig = r;
    if (v) begin
      sl[npix] = l;
      sr[npix] = r;
      ptag[npix] = cur_tag;
      if (npix >= NC - 1 && cyc + 1 < NCY) begin
        ev[cyc+1] = 1'b1;
        ep[cyc+1] = npix - (NC - 1);
      end
      npix++;
    end
  endtask

  function automatic logic [SW-1:0] rnd_sig();
    return SW'({$urandom(), $urandom()});
  endfunction

  // Planted shift: right pixel t shows the scene point of left pixel t+s.
  task automatic run_shift(input int count, input int s, input int thr, input bit noisy);
    for (int i = 0; i < count; i++) begin
      int t = npix;
      logic [SW-1:0] r = scene[t+s];
      if (noisy && ($urandom % 3 == 0)) r[$urandom % SW] ^= 1'b1;
      step(1'b1, scene[t], r, thr);
    end
  endtask

  initial begin
    for (int i = 0; i <= NPX + NC; i++) scene[i] = rnd_sig();
    for (int i = 0; i < NCY; i++) begin ev[i] = 1'b0; ep[i] = 0; end

    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_disp !== '0) begin
        errors++;
        $display("FAIL R9 in reset actual %0b/%0d expected 0/0", out_valid, out_disp);
      end
    end
    rst_n = 1'b1;

    // R3: forward search with a small planted shift
    cur_tag = 3;  run_shift(320, 5, 3, 1'b0);
    // R4: backward search with a large shift, many candidates past the row end
    cur_tag = 4;  run_shift(320, 40, 2, 1'b0);
    // R5: uniform signatures, every in-row score ties
    cur_tag = 5;
    begin
      logic [SW-1:0] k = rnd_sig();
      for (int i = 0; i < 200; i++) step(1'b1, k, k, 5);
    end
    // R10: zero threshold
    cur_tag = 10; run_shift(200, 7, 0, 1'b0);
    // R8: bubbles in the input
    cur_tag = 8;
    for (int i = 0; i < 200; i++) begin
      if (i % 3 == 1) step(1'b0, rnd_sig(), rnd_sig(), 4);
      if (i % 7 == 2) begin
        step(1'b0, rnd_sig(), rnd_sig(), 4);
        step(1'b0, rnd_sig(), rnd_sig(), 4);
      end
      step(1'b1, scene[npix], scene[npix+12], 4);
    end
    // R2: independent random streams, wide threshold
    cur_tag = 2;
    for (int i = 0; i < 200; i++) step(1'b1, rnd_sig(), rnd_sig(), 64);
    // R1: noisy shift with a tight threshold
    cur_tag = 1;  run_shift(200, 20, 1, 1'b1);
    // Flush so every pixel's result leaves
    cur_tag = 2;
    for (int i = 0; i < NC + 16; i++) step(1'b1, rnd_sig(), rnd_sig(), 3);
    for (int i = 0; i < LAT + 4; i++) step(1'b0, '0, '0, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule